// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Counter with Set Pulses

This block holds the time of day as seconds, minutes and hours on a twelve-hour dial and presents each field as a pair of seven-segment digit patterns. Everything runs on one system clock. A prescaler outside the block supplies a single-cycle strobe once per second. Debounced button logic supplies single-cycle pulses that step the minutes or the hours by hand.

Each strobe advances the seconds. The carry into minutes, and from there into hours, is decided in the same cycle as the strobe. All three counters are ordinary registers with enables. No counter output and no pulse is ever used as a clock. A manual set pulse uses the same enable path as the carry, so it obeys the same wrap limits. When a set pulse and a carry arrive for one field in the same cycle, the field still moves by a single step.

Top module: `clock12_counter`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the time reads 1:00:00 (hours 1, minutes 0, seconds 0).
- R2: Each cycle with `sec_tick` high adds one to the seconds. A tick at 59 seconds returns the seconds to 0.
- R3: Minutes step on a tick only when the seconds are at 59. A step from 59 minutes gives 0.
- R4: Hours step on a tick only when both the minutes and the seconds are at 59. A step from 12 gives 1. The hours never reach 0 or 13.
- R5: A cycle with no tick and no set pulse leaves all three fields unchanged.
- R6: A `min_set` pulse adds one to the minutes and wraps from 59 to 0. It never changes the hours or the seconds.
- R7: An `hr_set` pulse adds one to the hours and wraps from 12 to 1. It never changes the minutes or the seconds.
- R8: If a set pulse and a carry both call for a field to step in the same cycle, that field advances by exactly one.
- R9: Each 14-bit field output carries the tens digit in bits 13:7 and the units digit in bits 6:0. Within each digit, bit 6 is segment g and bit 0 is segment a, and a 1 lights the segment. The digits 0 to 9 are coded 0111111, 0000110, 1011011, 1001111, 1100110, 1101101, 1111101, 0000111, 1111111 and 1101111. A value below 10 shows 0 in the tens digit, hours included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset to 1:00:00 |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| min_set | input | 1 | One-cycle manual minute step |
| hr_set | input | 1 | One-cycle manual hour step |
| seg_sec | output | 14 | Seconds as tens and units segment patterns |
| seg_min | output | 14 | Minutes as tens and units segment patterns |
| seg_hr | output | 14 | Hours as tens and units segment patterns |

## Verification
The bench builds the block with its default limits: 59 for seconds and minutes, and 1 to 12 for hours. Under these limits the set pulses move minutes and hours to their top values within a few dozen cycles. A short run of ticks then reaches the full 12:59:59 to 1:00:00 rollover, the 59-to-0 minute wrap and the 12-to-1 hour wrap. The coincidence of a set pulse with a carry is also reached in a few hundred cycles, with no need to count a real day.

// File: rtl/clock12_pkg.sv
package clock12_pkg;
   localparam int SEG_W   = 7;
   localparam int FIELD_W = 2 * SEG_W;

   typedef logic [SEG_W-1:0]   seg_t;
   typedef logic [FIELD_W-1:0] field_seg_t;

   // Segment pattern for one decimal digit; bit 6 = g ... bit 0 = a, active high
   function automatic seg_t digit_to_seg(input logic [3:0] d);
      seg_t s;
      case (d)
         4'd0:    s = 7'b0111111;
         4'd1:    s = 7'b0000110;
         4'd2:    s = 7'b1011011;
         4'd3:    s = 7'b1001111;
         4'd4:    s = 7'b1100110;
         4'd5:    s = 7'b1101101;
         4'd6:    s = 7'b1111101;
         4'd7:    s = 7'b0000111;
         4'd8:    s = 7'b1111111;
         4'd9:    s = 7'b1101111;
         default: s = 7'b0000000;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/wrap_counter.sv
module wrap_counter #(
   parameter int W    = 6,
   parameter int LO   = 0,
   parameter int HI   = 59,
   parameter int INIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] value,
   output logic         at_top
);
   localparam logic [W-1:0] LO_V   = W'(LO);
   localparam logic [W-1:0] HI_V   = W'(HI);
   localparam logic [W-1:0] INIT_V = W'(INIT);

   if (HI >= (1 << W)) begin : g_bad_width
      $error("wrap_counter: HI does not fit in W bits");
   end
   if (LO > HI || INIT < LO || INIT > HI) begin : g_bad_range
      $error("wrap_counter: LO, INIT and HI out of order");
   end

   assign at_top = (value == HI_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= INIT_V;
      end else if (step) begin
         value <= at_top ? LO_V : value + 1'b1;
      end
   end
endmodule

// File: rtl/seg_field.sv
module seg_field
   import clock12_pkg::*;
#(
   parameter int VAL_W = 7
) (
   input  logic [VAL_W-1:0] val,
   output field_seg_t       seg
);
   if (VAL_W > 7) begin : g_bad_width
      $error("seg_field: values wider than two decimal digits");
   end

   logic [3:0] tens_d;
   logic [3:0] units_d;

   always_comb begin
      tens_d  = 4'(val / VAL_W'(10));
      units_d = 4'(val % VAL_W'(10));
      seg     = {digit_to_seg(tens_d), digit_to_seg(units_d)};
   end
endmodule

// File: rtl/clock12_counter.sv
module clock12_counter
   import clock12_pkg::*;
#(
   parameter int SEC_TOP = 59,
   parameter int MIN_TOP = 59,
   parameter int HR_LO   = 1,
   parameter int HR_TOP  = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sec_tick,
   input  logic         min_set,
   input  logic         hr_set,
   output logic [13:0]  seg_sec,
   output logic [13:0]  seg_min,
   output logic [13:0]  seg_hr
);
   localparam int SEC_W   = $clog2(SEC_TOP + 1);
   localparam int MIN_W   = $clog2(MIN_TOP + 1);
   localparam int HR_W    = $clog2(HR_TOP + 1);
   localparam int NFIELD  = 3;
   localparam int DISP_W  = 7;

   if (SEC_TOP > 99 || MIN_TOP > 99 || HR_TOP > 99) begin : g_bad_top
      $error("clock12_counter: a field exceeds two digits");
   end
   if (HR_LO < 0 || HR_LO > HR_TOP) begin : g_bad_hr
      $error("clock12_counter: hour range inverted");
   end

   logic [SEC_W-1:0] sec_v;
   logic [MIN_W-1:0] min_v;
   logic [HR_W-1:0]  hr_v;
   logic             sec_top, min_top, hr_top;
   logic             min_carry, hr_carry;
   logic             min_step, hr_step;

   // carry chain and manual steps share one enable per field (OR: one step max)
   assign min_carry = sec_tick & sec_top;
   assign hr_carry  = min_carry & min_top;
   assign min_step  = min_carry | min_set;
   assign hr_step   = hr_carry  | hr_set;

   wrap_counter #(.W(SEC_W), .LO(0), .HI(SEC_TOP), .INIT(0)) u_sec (
      .clk(clk), .rst_n(rst_n), .step(sec_tick), .value(sec_v), .at_top(sec_top)
   );
   wrap_counter #(.W(MIN_W), .LO(0), .HI(MIN_TOP), .INIT(0)) u_min (
      .clk(clk), .rst_n(rst_n), .step(min_step), .value(min_v), .at_top(min_top)
   );
   wrap_counter #(.W(HR_W), .LO(HR_LO), .HI(HR_TOP), .INIT(HR_LO)) u_hr (
      .clk(clk), .rst_n(rst_n), .step(hr_step), .value(hr_v), .at_top(hr_top)
   );

   logic [DISP_W-1:0] disp_val [NFIELD];
   field_seg_t        disp_seg [NFIELD];

   assign disp_val[0] = DISP_W'(sec_v);
   assign disp_val[1] = DISP_W'(min_v);
   assign disp_val[2] = DISP_W'(hr_v);

   for (genvar f = 0; f < NFIELD; f++) begin : g_disp
      seg_field #(.VAL_W(DISP_W)) u_seg (
         .val(disp_val[f]),
         .seg(disp_seg[f])
      );
   end

   assign seg_sec = disp_seg[0];
   assign seg_min = disp_seg[1];
   assign seg_hr  = disp_seg[2];

   logic unused_hr_top;
   assign unused_hr_top = hr_top;
endmodule

// File: rtl/clock12_checker.sv
module clock12_checker #(
   parameter int SEC_W   = 6,
   parameter int MIN_W   = 6,
   parameter int HR_W    = 4,
   parameter int SEC_TOP = 59,
   parameter int MIN_TOP = 59,
   parameter int HR_LO   = 1,
   parameter int HR_TOP  = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sec_tick,
   input logic             min_set,
   input logic             hr_set,
   input logic [SEC_W-1:0] sec_v,
   input logic [MIN_W-1:0] min_v,
   input logic [HR_W-1:0]  hr_v
);
   localparam logic [SEC_W-1:0] S_TOP = SEC_W'(SEC_TOP);
   localparam logic [MIN_W-1:0] M_TOP = MIN_W'(MIN_TOP);
   localparam logic [HR_W-1:0]  H_TOP = HR_W'(HR_TOP);
   localparam logic [HR_W-1:0]  H_LO  = HR_W'(HR_LO);

   a_r1_reset_time: assert property (@(posedge clk)
      $rose(rst_n) |-> (sec_v == '0 && min_v == '0 && hr_v == H_LO));

   a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && sec_v != S_TOP) |=> sec_v == SEC_W'($past(sec_v) + 1'b1));

   a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && sec_v == S_TOP) |=> sec_v == '0);

   a_r3_min_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && sec_v == S_TOP && min_v == M_TOP) |=> min_v == '0);

   a_r4_hr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (hr_v >= H_LO && hr_v <= H_TOP));

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !min_set && !hr_set) |=> ($stable(sec_v) && $stable(min_v) && $stable(hr_v)));

   a_r6_min_set_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (min_set && !hr_set && !sec_tick) |=> ($stable(hr_v) && $stable(sec_v)));

   a_r7_hr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (hr_set && hr_v == H_TOP) |=> hr_v == H_LO);

   a_r8_min_once: assert property (@(posedge clk) disable iff (!rst_n)
      (min_set && sec_tick && sec_v == S_TOP && min_v != M_TOP)
      |=> min_v == MIN_W'($past(min_v) + 1'b1));
endmodule

bind clock12_counter clock12_checker #(
   .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W),
   .SEC_TOP(SEC_TOP), .MIN_TOP(MIN_TOP), .HR_LO(HR_LO), .HR_TOP(HR_TOP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_set(min_set), .hr_set(hr_set),
   .sec_v(sec_v), .min_v(min_v), .hr_v(hr_v)
);

// File: tb/sim_clock12_counter.sv
`timescale 1ns/1ps
module sim_clock12_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        min_set = 1'b0;
   logic        hr_set = 1'b0;
   logic [13:0] seg_sec, seg_min, seg_hr;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   int ms = 0, mm = 0, mh = 1;

   logic [41:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   clock12_counter u0 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_set(min_set), .hr_set(hr_set),
      .seg_sec(seg_sec), .seg_min(seg_min), .seg_hr(seg_hr)
   );

   function automatic logic [6:0] dseg(input int d);
      case (d)
         0: return 7'b0111111;
         1: return 7'b0000110;
         2: return 7'b1011011;
         3: return 7'b1001111;
         4: return 7'b1100110;
         5: return 7'b1101101;
         6: return 7'b1111101;
         7: return 7'b0000111;
         8: return 7'b1111111;
         9: return 7'b1101111;
         default: return 7'b0000000;
      endcase
   endfunction

   function automatic logic [13:0] fpat(input int v);
      return {dseg(v / 10), dseg(v % 10)};
   endfunction

   function automatic logic [41:0] model_pat();
      return {fpat(mh), fpat(mm), fpat(ms)};
   endfunction

   task automatic check(input string tag, input logic [41:0] act, input logic [41:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual h/m/s=%h expected %h", tag, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, model update, expectation pushed
   task automatic drive(input bit t, input bit ms_p, input bit hs_p, input string tag);
      bit cm, ch;
      @(negedge clk);
      sec_tick = t; min_set = ms_p; hr_set = hs_p;
      cm = t && (ms == 59);
      ch = cm && (mm == 59);
      if (t)          ms = (ms == 59) ? 0 : ms + 1;
      if (cm || ms_p) mm = (mm == 59) ? 0 : mm + 1;
      if (ch || hs_p) mh = (mh == 12) ? 1 : mh + 1;
      exp_q.push_back(model_pat());
      tag_q.push_back(tag);
   endtask

   task automatic idle_inputs();
      @(negedge clk);
      sec_tick = 1'b0; min_set = 1'b0; hr_set = 1'b0;
   endtask

   // monitor: compare the state after each clock edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [41:0] e;
            string       tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(tg, {seg_hr, seg_min, seg_sec}, e);
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: during reset
      check("R1 in reset", {seg_hr, seg_min, seg_sec}, model_pat());
      // R9: literal patterns for 01 and 00
      check("R9 hour 01 pattern", {28'd0, seg_hr}, {28'd0, 14'b0111111_0000110});
      check("R9 zero pattern", {14'd0, seg_min, seg_sec}, {14'd0, 14'b0111111_0111111, 14'b0111111_0111111});
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 after release", {seg_hr, seg_min, seg_sec}, model_pat());

      // R2: seconds advance
      for (int i = 0; i < 5; i++) drive(1, 0, 0, "R2 tick");
      // R5: idle holds
      for (int i = 0; i < 4; i++) drive(0, 0, 0, "R5 idle");
      // R6: minute set up to 59, then wrap without hour carry
      for (int i = 0; i < 59; i++) drive(0, 1, 0, "R6 min set");
      drive(0, 1, 0, "R6 min wrap no carry");
      for (int i = 0; i < 59; i++) drive(0, 1, 0, "R6 min set");
      // R2/R3/R4: ticks to 59 then full carry into hours
      while (ms != 59) drive(1, 0, 0, "R2 tick");
      drive(1, 0, 0, "R4 carry to hours R3 wrap");
      // R7: hour set to 12 and wrap to 1
      while (mh != 12) drive(0, 0, 1, "R7 hr set");
      drive(0, 0, 1, "R7 hr wrap 12 to 1");
      // R4: rollover 12:59:59 -> 1:00:00
      while (mh != 12) drive(0, 0, 1, "R7 hr set");
      while (mm != 59) drive(0, 1, 0, "R6 min set");
      while (ms != 59) drive(1, 0, 0, "R2 tick");
      drive(1, 0, 0, "R4 rollover 12 to 1");
      // R3: minute step on second carry
      while (ms != 59) drive(1, 0, 0, "R2 tick");
      drive(1, 0, 0, "R3 minute carry");
      // R8: set pulse coincident with minute carry
      while (ms != 59) drive(1, 0, 0, "R2 tick");
      drive(1, 1, 0, "R8 min set with carry");
      // R8: set pulse coincident with hour carry
      while (mm != 59) drive(0, 1, 0, "R6 min set");
      while (ms != 59) drive(1, 0, 0, "R2 tick");
      drive(1, 0, 1, "R8 hr set with carry");
      drive(0, 1, 1, "R6 R7 both sets");
      idle_inputs();
      repeat (3) @(negedge clk);
      check("R5 final hold", {seg_hr, seg_min, seg_sec}, model_pat());
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule